// File: doc/BRIEF.md
# Programmable Color Space Matrix

This block converts a stream of pixels, each carrying three 8-bit components, from one color space to another with a programmable 3x3 matrix. Every output component is a weighted sum of the three input components plus a per-row offset, multiplied by a power of two, rounded and then limited to a legal range. With the matching settings the same hardware turns RGB into YCbCr or YCbCr into RGB, or passes graphics data through unchanged for a later combining stage.

The settings are written one word at a time into a staging bank through a simple write port. They take effect together on a frame-start strobe, so the stream never sees a half-written matrix. Pixels enter and leave on valid/ready handshakes. The arithmetic runs in a three-stage pipeline that accepts one pixel per clock. When the consumer holds back, the whole pipeline stalls, and the stall reaches the producer through the input ready.

Top module: `pix_csc_matrix`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, and the active settings are the identity matrix (128 on the diagonal, zero elsewhere, zero offsets, scale code 2, saturate off), so every pixel leaves unchanged.
- R2: For row r, with x0..x2 the unsigned input components (x0 = in_pix[7:0], x1 = in_pix[15:8], x2 = in_pix[23:16]), signed 9-bit coefficients c0..c2 and a signed 13-bit offset o (in units of a quarter of a code at scale code 1), the pre-rounding value is S = (c0*x0 + c1*x1 + c2*x2 + 64*o) * 2^scale. Row r drives out_pix[8r+7:8r].
- R3: The result is floor((S + 256) / 512), so it rounds to the nearest code and an exact half rounds toward plus infinity.
- R4: With saturate off, any result below 0 gives 0 and any result above 255 gives 255.
- R5: With saturate on, row 0 is limited to 16..235 and rows 1 and 2 are limited to 16..240.
- R6: A pixel accepted at a clock edge passes three registers and is presented on out_valid/out_pix after the second following edge, when out_ready stays high.
- R7: in_ready equals (not out_valid) or out_ready; while out_valid is high and out_ready low, out_valid and out_pix hold their values at the next edge.
- R8: Writes go to a staging bank. Address 0..2 holds the coefficients of row 0..2 as {c2 in [26:18], c1 in [17:9], c0 in [8:0]}. Address 3..5 holds the offset of row 0..2 in [12:0]. Address 6 holds scale in [1:0] and saturate in [2]. Address 7 is ignored. Staged values do not affect the output until frame_start.
- R9: On an edge with frame_start high, the whole staging bank, including a write made at that same edge, becomes the active setting. Scale codes 0 to 3 give factors 1/2, 1, 2 and 4 relative to a coefficient of 256 as unity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the staging bank |
| cfg_addr | input | 3 | Staging word address |
| cfg_wdata | input | 27 | Staging write data |
| frame_start | input | 1 | Copies the staging bank into the active setting |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Pipeline can take a pixel this cycle |
| in_pix | input | 24 | Input components, component 0 in the low byte |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_pix | output | 24 | Output components, row 0 in the low byte |

## Verification
The bench builds the block with its default parameters: 8-bit components, 9-bit coefficients, 13-bit offsets and saturation ceilings of 235 and 240. These widths let random settings reach the coefficient extremes of -256 and +255, offsets across the whole signed range and all four scale codes, so clamping at both ends and exact rounding ties both occur. Random stalls on the output side, with gaps on the input side, drive the pipeline through fill, full hold and drain.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    localparam int PW      = 8;            // bits per component
    localparam int NCH     = 3;            // components per pixel and matrix rows
    localparam int CW      = 9;            // coefficient width
    localparam int OW      = 13;           // offset width
    localparam int SCW     = 2;            // scale code width
    localparam int OFS_SH  = 6;            // offset alignment to the product sum
    localparam int RND_SH  = PW + 1;       // final right shift
    localparam int PIPE_D  = 3;            // register stages
    localparam int PROD_W  = PW + 1 + CW;  // signed product width
    localparam int ACC_W   = PROD_W + 4;   // room for sum and offset
    localparam int SCL_W   = ACC_W + (1 << SCW);
    localparam int CFG_AW  = 3;
    localparam int CFG_DW  = NCH * CW;
    localparam int UNITY_ID = 128;         // identity diagonal at scale code 2

    typedef logic signed [CW-1:0]     coef_t;
    typedef logic signed [OW-1:0]     ofs_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [SCL_W-1:0]  scl_t;

    typedef struct packed {
        coef_t [NCH-1:0] c;
        ofs_t            o;
    } row_cfg_t;

    typedef struct packed {
        row_cfg_t [NCH-1:0] row;
        logic [SCW-1:0]     scale;
        logic               sat;
    } mtx_cfg_t;

    typedef struct packed {
        mtx_cfg_t stage;
        mtx_cfg_t act;
    } cfg_st_t;

    typedef struct packed {
        prod_t [NCH-1:0] prod;
        acc_t            acc;
        logic [PW-1:0]   y;
        logic            sat_used;
    } row_st_t;

    typedef struct packed {
        logic [PIPE_D-1:0] v;
    } flow_st_t;

    function automatic mtx_cfg_t ident_cfg();
        mtx_cfg_t c;
        c = '0;
        for (int r = 0; r < NCH; r++) begin
            c.row[r].c[r] = coef_t'(UNITY_ID);
        end
        c.scale = SCW'(2);
        return c;
    endfunction

endpackage

// File: rtl/pcm_cfg_bank.sv
module pcm_cfg_bank
    import pcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    input  logic              frame_start,
    output mtx_cfg_t          active
);

    localparam int MODE_ADDR = 2 * NCH;

    cfg_st_t d, q;

    always_comb begin
        d = q;
        if (we) begin
            for (int r = 0; r < NCH; r++) begin
                if (addr == CFG_AW'(r)) begin
                    for (int j = 0; j < NCH; j++) begin
                        d.stage.row[r].c[j] = coef_t'(wdata[j*CW +: CW]);
                    end
                end
                if (addr == CFG_AW'(NCH + r)) begin
                    d.stage.row[r].o = ofs_t'(wdata[OW-1:0]);
                end
            end
            if (addr == CFG_AW'(MODE_ADDR)) begin
                d.stage.scale = wdata[SCW-1:0];
                d.stage.sat   = wdata[SCW];
            end
        end
        if (frame_start) begin
            d.act = d.stage;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.stage <= ident_cfg();
            q.act   <= ident_cfg();
        end else begin
            q <= d;
        end
    end

    assign active = q.act;

    // R8: the active setting only moves on a frame-start edge
    a_r8_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(q.act));

endmodule

// File: rtl/pcm_flow.sv
module pcm_flow
    import pcm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic adv,
    output logic out_valid
);

    flow_st_t d, q;
    logic     adv_c;

    always_comb begin
        adv_c = !q.v[PIPE_D-1] || out_ready;
        d     = q;
        if (adv_c) begin
            d.v = {q.v[PIPE_D-2:0], in_valid};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign adv       = adv_c;
    assign in_ready  = adv_c;
    assign out_valid = q.v[PIPE_D-1];

endmodule

// File: rtl/pcm_row_mac.sv
module pcm_row_mac
    import pcm_pkg::*;
#(
    parameter int HI_SAT = 235,
    parameter int LO_SAT = 16
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic [NCH*PW-1:0]  x,
    input  row_cfg_t           rc,
    input  logic [SCW-1:0]     scale,
    input  logic               sat,
    output logic [PW-1:0]      y
);

    localparam int FULL_MAX = (1 << PW) - 1;

    row_st_t d, q;

    always_comb begin
        acc_t sum_v;
        scl_t scl_v;
        scl_t rnd_v;
        scl_t lo_v;
        scl_t hi_v;
        d     = q;
        sum_v = '0;
        scl_v = '0;
        rnd_v = '0;
        lo_v  = '0;
        hi_v  = '0;
        if (adv) begin
            // stage 1: products of unsigned components and signed coefficients
            for (int j = 0; j < NCH; j++) begin
                d.prod[j] = prod_t'($signed({1'b0, x[j*PW +: PW]}))
                          * prod_t'($signed(rc.c[j]));
            end
            // stage 2: sum of products plus aligned offset
            sum_v = acc_t'($signed(q.prod[0]))
                  + acc_t'($signed(q.prod[1]))
                  + acc_t'($signed(q.prod[2]))
                  + (acc_t'($signed(rc.o)) <<< OFS_SH);
            d.acc = sum_v;
            // stage 3: power-of-two scale, round, clamp
            scl_v = scl_t'($signed(q.acc)) <<< scale;
            rnd_v = (scl_v + (scl_t'(1) <<< (RND_SH - 1))) >>> RND_SH;
            lo_v  = sat ? scl_t'(LO_SAT) : scl_t'(0);
            hi_v  = sat ? scl_t'(HI_SAT) : scl_t'(FULL_MAX);
            if (rnd_v < lo_v) begin
                d.y = lo_v[PW-1:0];
            end else if (rnd_v > hi_v) begin
                d.y = hi_v[PW-1:0];
            end else begin
                d.y = rnd_v[PW-1:0];
            end
            d.sat_used = sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign y = q.y;

    // R5: a result produced with saturate on lies inside the video range
    a_r5_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.sat_used |-> (q.y >= PW'(LO_SAT) && q.y <= PW'(HI_SAT)));

endmodule

// File: rtl/pix_csc_matrix.sv
module pix_csc_matrix
    import pcm_pkg::*;
#(
    parameter int LUMA_MAX   = 235,
    parameter int CHROMA_MAX = 240,
    parameter int RANGE_MIN  = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              frame_start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NCH*PW-1:0] in_pix,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [NCH*PW-1:0] out_pix
);

    mtx_cfg_t act;
    logic     adv;

    pcm_cfg_bank u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .frame_start (frame_start),
        .active      (act)
    );

    pcm_flow u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .adv       (adv),
        .out_valid (out_valid)
    );

    for (genvar r = 0; r < NCH; r++) begin : g_row
        pcm_row_mac #(
            .HI_SAT (r == 0 ? LUMA_MAX : CHROMA_MAX),
            .LO_SAT (RANGE_MIN)
        ) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .x     (in_pix),
            .rc    (act.row[r]),
            .scale (act.scale),
            .sat   (act.sat),
            .y     (out_pix[r*PW +: PW])
        );
    end

    // R7: a refused output stays put
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

    // R6: an accepted pixel shows up two edges later with no stall
    a_r6_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && out_ready) ##1 out_ready ##1 out_ready |=> out_valid);

endmodule

// File: tb/pix_csc_matrix_tb.sv
module pix_csc_matrix_tb;
    import pcm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [26:0] cfg_wdata;
    logic        frame_start;
    logic        in_valid;
    logic        in_ready;
    logic [23:0] in_pix;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_pix;

    always #5 clk = ~clk;

    pix_csc_matrix u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_ready(in_ready), .in_pix(in_pix), .out_valid(out_valid),
        .out_ready(out_ready), .out_pix(out_pix)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int sc[3][3]; int so[3]; int ssc; int ssat;
    int ac[3][3]; int ao[3]; int asc; int asat;
    bit mv[3];
    logic [23:0] mp[3];

    function automatic void model_ident();
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < 3; j++) sc[r][j] = (r == j) ? 128 : 0;
            so[r] = 0;
        end
        ssc = 2; ssat = 0;
        ac = sc; ao = so; asc = ssc; asat = ssat;
    endfunction

    function automatic logic [23:0] model_out(logic [23:0] p);
        logic [23:0] res;
        int acc, t, v, lo, hi;
        res = '0;
        for (int r = 0; r < 3; r++) begin
            acc = ao[r] * 64;
            for (int j = 0; j < 3; j++) acc += ac[r][j] * int'(p[j*8 +: 8]);
            t  = acc * (1 << asc);
            v  = (t + 256) >>> 9;
            lo = asat ? 16 : 0;
            hi = asat ? ((r == 0) ? 235 : 240) : 255;
            if (v < lo) v = lo;
            if (v > hi) v = hi;
            res[r*8 +: 8] = v[7:0];
        end
        return res;
    endfunction

    initial model_ident();

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) mv[i] = 1'b0;
            model_ident();
        end else begin
            if (!mv[2] || out_ready) begin
                mv[2] = mv[1]; mp[2] = mp[1];
                mv[1] = mv[0]; mp[1] = mp[0];
                mv[0] = in_valid; mp[0] = model_out(in_pix);
            end
            if (cfg_we) begin
                if (cfg_addr < 3) begin
                    for (int j = 0; j < 3; j++)
                        sc[cfg_addr][j] = int'($signed(cfg_wdata[j*9 +: 9]));
                end else if (cfg_addr < 6) begin
                    so[cfg_addr - 3] = int'($signed(cfg_wdata[12:0]));
                end else if (cfg_addr == 6) begin
                    ssc  = int'(cfg_wdata[1:0]);
                    ssat = int'(cfg_wdata[2]);
                end
            end
            if (frame_start) begin
                ac = sc; ao = so; asc = ssc; asat = ssat;
            end
        end
    end

    // per-cycle comparison against the model (R7 handshake, all arithmetic)
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            n_cmp++;
            if (out_valid !== mv[2] || (mv[2] && out_pix !== mp[2]) ||
                in_ready !== (!mv[2] || out_ready)) begin
                n_bad++;
                $display("FAIL %s per-cycle: valid=%0b pix=%h ready=%0b expected valid=%0b pix=%h ready=%0b",
                         cur_req, out_valid, out_pix, in_ready, mv[2], mp[2], !mv[2] || out_ready);
            end
        end
    end

    task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [26:0] dta, input logic fs);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = dta; frame_start = fs;
        @(negedge clk);
        cfg_we = 1'b0; frame_start = 1'b0;
    endtask

    task automatic fstart();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    function automatic logic [26:0] pk(int a, int b, int c);
        return {9'(c), 9'(b), 9'(a)};
    endfunction

    task automatic stage_all(input logic [26:0] w0, w1, w2, input int o0, o1, o2,
                             input int s, input int st, input logic fs);
        wr(3'd0, w0, 1'b0); wr(3'd1, w1, 1'b0); wr(3'd2, w2, 1'b0);
        wr(3'd3, 27'(13'(o0)), 1'b0); wr(3'd4, 27'(13'(o1)), 1'b0);
        wr(3'd5, 27'(13'(o2)), 1'b0);
        wr(3'd6, 27'({st[0], s[1:0]}), fs);
    endtask

    // one pixel through an idle pipeline; checks value and R6 timing
    task automatic one_pix(input logic [23:0] p, input logic [23:0] exp, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_pix = p;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk({req, " R6 valid"}, {23'd0, out_valid}, 24'd1);
        chk(req, out_pix, exp);
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        frame_start = 1'b0; in_valid = 1'b0; in_pix = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";
        chk("R1 out_valid after reset", {23'd0, out_valid}, 24'd0);
        chk("R1 in_ready after reset", {23'd0, in_ready}, 24'd1);
        one_pix(24'h1E140A, 24'h1E140A, "R1 identity pass");

        // R8: staged matrix does not act before frame_start
        cur_req = "R8";
        stage_all(pk(77, 150, 29), pk(-43, -85, 128), pk(128, -107, -21),
                  0, 512, 512, 1, 0, 1'b0);
        wr(3'd7, 27'h7FFFFFF, 1'b0);
        one_pix(24'hFFFFFF, 24'hFFFFFF, "R8 staged only");
        fstart();
        cur_req = "R2";
        one_pix(24'hFFFFFF, 24'h8080FF, "R2 rgb to ycc white");
        one_pix(24'h000000, 24'h808000, "R2 rgb to ycc black");

        stage_all(pk(149, 0, 204), pk(149, -50, -104), pk(149, 255, 0),
                  -446, 266, -554, 2, 0, 1'b1);
        one_pix(24'h808010, 24'h000000, "R2 ycc to rgb black");

        cur_req = "R5";
        stage_all(pk(128, 0, 0), pk(0, 128, 0), pk(0, 0, 128), 0, 0, 0, 2, 1, 1'b1);
        one_pix(24'h000000, 24'h101010, "R5 floor");
        one_pix(24'hFFFFFF, 24'hF0F0EB, "R5 ceilings");

        cur_req = "R3";
        stage_all(pk(1, 0, 0), pk(-1, 0, 0), pk(0, 0, 0), 0, 0, 2, 1, 0, 1'b1);
        one_pix(24'h000080, 24'h010001, "R3 ties round up");
        one_pix(24'h00007F, 24'h010000, "R3 below half");

        cur_req = "R4";
        stage_all(pk(128, 0, 0), pk(0, 128, 0), pk(0, 0, -128), 0, 0, 0, 3, 0, 1'b1);
        one_pix(24'h32C864, 24'h00FFC8, "R4 clamp both ends");

        // R9: mode write on the frame_start edge itself is taken
        cur_req = "R9";
        stage_all(pk(128, 0, 0), pk(0, 128, 0), pk(0, 0, 128), 0, 0, 0, 2, 0, 1'b1);
        wr(3'd6, 27'd0, 1'b1);
        one_pix(24'hFF060A, 24'h400203, "R9 scale code 0");

        // R7: random traffic and stalls, random settings
        cur_req = "R7";
        for (int k = 0; k < 6; k++) begin
            drain();
            stage_all(pk($urandom_range(0, 511) - 256, $urandom_range(0, 511) - 256, $urandom_range(0, 511) - 256),
                      pk($urandom_range(0, 511) - 256, $urandom_range(0, 511) - 256, $urandom_range(0, 511) - 256),
                      pk($urandom_range(0, 511) - 256, $urandom_range(0, 511) - 256, $urandom_range(0, 511) - 256),
                      $urandom_range(0, 8191) - 4096, $urandom_range(0, 8191) - 4096,
                      $urandom_range(0, 8191) - 4096, $urandom_range(0, 3), $urandom_range(0, 1), 1'b1);
            for (int c = 0; c < 1500; c++) begin
                @(negedge clk);
                in_valid  = $urandom_range(0, 1) == 1;
                in_pix    = 24'($urandom);
                out_ready = $urandom_range(0, 3) != 0;
            end
        end
        drain();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL %s watchdog: got hung run expected completion", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule